// File: doc/BRIEF.md
# Multi-lane SPI data shifter

This block is the data-moving core of a serial memory slave. It sits behind the opcode decoder and moves bytes over one, two or four I/O lanes. In transmit use it takes bytes from a ready/valid source. It spreads each byte over the lanes in a fixed bit pattern and keeps streaming byte after byte while chip select stays low. In capture use it listens on two lanes for sixteen clocks. It then presents a 24-bit address and an 8-bit mode byte with a one-clock valid pulse. Every rising edge of `clk` while `cs_n` is low counts as one serial clock. The lanes are modelled as separate output, output-enable and input signals, and a lane is enabled only while it carries data.

The controller has five states. IDLE waits for a select. Its transition "start" goes to SEND when a byte is accepted, and its transition "listen" goes to CAPT when `cap_en` is high. SEND shifts one beat per clock. Its transition "chain" reloads at the last beat when the source is valid, and its transition "starve" goes to STALL when the source is not. STALL keeps the lanes released, and its transition "resume" returns to SEND on the next accepted byte. CAPT samples two lanes per clock, and its transition "filled" goes to HOLD after the sixteenth sample. HOLD ignores the lanes. From every state the transition "deselect" returns to IDLE when `cs_n` is high.

Top module: `mlspi_shifter`

## Requirements
- R1: With `lane_sel`=00 (single), a byte takes 8 clocks. Only lane 0 is driven (`lane_oe`=0001), and it carries bit 7 first, then bits 6 down to 0.
- R2: With `lane_sel`=01 (dual), a byte takes 4 clocks and `lane_oe`=0011. On successive clocks lane 0 carries bits 6, 4, 2, 0 and lane 1 carries bits 7, 5, 3, 1.
- R3: With `lane_sel` bit 1 set (10 or 11, quad), a byte takes 2 clocks and `lane_oe`=1111. Lanes 0..3 carry bits 4..7 on the first clock and bits 0..3 on the second.
- R4: `src_ready` is high during the last beat of a byte. A byte accepted then starts on the very next clock with no gap. `byte_done` pulses for one clock in the cycle after each completed byte.
- R5: If no byte is valid at the last beat, then in the next cycle `lane_oe`=0000 and `underrun` pulses for one clock. The lanes stay released until a byte is accepted, and that byte is driven from its first beat in the cycle after acceptance.
- R6: While `cs_n` is high, `lane_oe`=0000 and `src_ready`=0 in the same cycle, and no `byte_done` or `underrun` follows. A partial byte is dropped, and the next select starts a new byte at its first beat.
- R7: When `cap_en` is high at the first clock of a select, the block samples `cap_lanes` on 16 clocks, with lane 1 as the more significant bit of each pair. In the cycle after the 16th sample, `cap_valid` pulses and `cap_addr` and `cap_mode` hold the first 24 and the last 8 of the 32 received bits, most significant first. No lane is driven during capture.
- R8: After a completed capture, further clocks under the same select produce no new `cap_valid`. A select that ends mid-capture is discarded, and the next capture counts from its first sample.
- R9: After reset with `cs_n` high, `lane_oe`, `src_ready`, `byte_done`, `underrun` and `cap_valid` are all 0.
- R10: The lane mode is taken when a byte is loaded. Changing `lane_sel` in the middle of a byte does not change how the rest of that byte is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; one beat per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| lane_sel | input | 2 | Lane mode: 00 single, 01 dual, 1x quad |
| cap_en | input | 1 | Capture an address at the start of a select |
| src_data | input | 8 | Byte offered by the source |
| src_valid | input | 1 | Source byte is valid |
| src_ready | output | 1 | Shifter accepts a byte this cycle |
| lane_out | output | 4 | Values driven onto lanes 3..0 |
| lane_oe | output | 4 | Per-lane output enable |
| cap_lanes | input | 2 | Lanes 1..0 sampled during capture |
| byte_done | output | 1 | One-clock pulse after each completed byte |
| underrun | output | 1 | One-clock pulse when a byte was due and missing |
| cap_addr | output | ADDR_W | Captured address |
| cap_mode | output | MODE_W | Captured mode byte |
| cap_valid | output | 1 | One-clock pulse when capture completes |

## Verification
The first beat of an accepted byte appears on the lanes one clock after the accepting edge. Each later beat follows one clock after the one before it, and `byte_done` and `underrun` arrive one clock after the edge that ends the last beat. `cap_valid` and the captured fields arrive one clock after the sixteenth sampling edge. The effect of `cs_n` on `lane_oe` and `src_ready` is seen at once, with no clock edge. The bench drives inputs on the falling edge and samples on the following falling edge, after exactly the number of rising edges listed here. For the combinational deselect checks it samples a moment after the change.

// File: rtl/mlspi_pkg.sv
package mlspi_pkg;

    localparam int BYTE_W = 8;
    localparam int LANES  = 4;

    typedef enum logic [1:0] {
        LM_SINGLE = 2'd0,
        LM_DUAL   = 2'd1,
        LM_QUAD   = 2'd2
    } lane_mode_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SEND  = 3'd1,
        ST_STALL = 3'd2,
        ST_CAPT  = 3'd3,
        ST_HOLD  = 3'd4
    } shf_state_t;

    function automatic lane_mode_t decode_mode(input logic [1:0] sel);
        if (sel[1])
            return LM_QUAD;
        else if (sel[0])
            return LM_DUAL;
        else
            return LM_SINGLE;
    endfunction

endpackage

// File: rtl/mlspi_tx_lanes.sv
module mlspi_tx_lanes
    import mlspi_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  load,
    input  logic [BYTE_W-1:0]     load_data,
    input  lane_mode_t            load_mode,
    input  logic                  step,
    output logic [LANES-1:0]      lanes,
    output logic [LANES-1:0]      mask,
    output logic                  last_o
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic [BYTE_W-1:0] sr_q;
    logic [CNT_W-1:0]  cnt_q;
    lane_mode_t        amode_q;
    logic [CNT_W-1:0]  last_cnt;

    always_comb begin
        unique case (amode_q)
            LM_SINGLE: begin
                lanes    = {3'b000, sr_q[7]};
                mask     = 4'b0001;
                last_cnt = CNT_W'(BYTE_W - 1);
            end
            LM_DUAL: begin
                lanes    = {2'b00, sr_q[7:6]};
                mask     = 4'b0011;
                last_cnt = CNT_W'(BYTE_W / 2 - 1);
            end
            default: begin
                lanes    = sr_q[7:4];
                mask     = 4'b1111;
                last_cnt = CNT_W'(BYTE_W / 4 - 1);
            end
        endcase
    end

    assign last_o = (cnt_q == last_cnt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q    <= '0;
            cnt_q   <= '0;
            amode_q <= LM_SINGLE;
        end else if (clear) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            sr_q    <= load_data;
            cnt_q   <= '0;
            amode_q <= load_mode;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
            unique case (amode_q)
                LM_SINGLE: sr_q <= {sr_q[6:0], 1'b0};
                LM_DUAL:   sr_q <= {sr_q[5:0], 2'b00};
                default:   sr_q <= {sr_q[3:0], 4'b0000};
            endcase
        end
    end

    // R4: the controller never steps beyond the final beat of a byte
    assert_no_overstep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !last_o);

    // R6: a clear always returns the beat counter to the start
    assert_clear_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !load) |=> (cnt_q == '0));

endmodule

// File: rtl/mlspi_rx_capture.sv
module mlspi_rx_capture #(
    parameter int ADDR_W = 24,
    parameter int MODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic [1:0]        din,
    output logic              last_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              valid_o
);
    localparam int WORD_W = ADDR_W + MODE_W;
    localparam int BEATS  = WORD_W / 2;
    localparam int CNT_W  = $clog2(BEATS);

    logic [WORD_W-3:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] word;

    assign word   = {sh_q, din};
    assign last_o = (cnt_q == CNT_W'(BEATS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            cnt_q   <= '0;
            addr_o  <= '0;
            mode_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (clear) begin
                cnt_q <= '0;
            end else if (sample) begin
                sh_q  <= word[WORD_W-3:0];
                cnt_q <= cnt_q + 1'b1;
                if (last_o) begin
                    addr_o  <= word[WORD_W-1:MODE_W];
                    mode_o  <= word[MODE_W-1:0];
                    valid_o <= 1'b1;
                end
            end
        end
    end

    // R7: a completed capture signals exactly one clock
    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R8: a deselect discards any partial capture count
    assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0) && !valid_o);

endmodule

// File: rtl/mlspi_shifter.sv
module mlspi_shifter
    import mlspi_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int MODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic [1:0]        lane_sel,
    input  logic              cap_en,
    input  logic [7:0]        src_data,
    input  logic              src_valid,
    output logic              src_ready,
    output logic [3:0]        lane_out,
    output logic [3:0]        lane_oe,
    input  logic [1:0]        cap_lanes,
    output logic              byte_done,
    output logic              underrun,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [MODE_W-1:0] cap_mode,
    output logic              cap_valid
);
    shf_state_t st_q, st_d;

    logic       live;
    logic       tx_last, tx_load, tx_step;
    logic [3:0] tx_lanes, tx_mask;
    logic       cap_last, cap_sample;
    logic       done_d, unr_d;

    assign live = !cs_n;

    // next state and strobes
    always_comb begin
        st_d       = st_q;
        done_d     = 1'b0;
        unr_d      = 1'b0;
        cap_sample = 1'b0;
        src_ready  = 1'b0;
        if (!live) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (cap_en) begin
                        cap_sample = 1'b1;
                        st_d       = ST_CAPT;
                    end else begin
                        src_ready = 1'b1;
                        if (src_valid) st_d = ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (tx_last) begin
                        src_ready = 1'b1;
                        done_d    = 1'b1;
                        if (!src_valid) begin
                            unr_d = 1'b1;
                            st_d  = ST_STALL;
                        end
                    end
                end
                ST_STALL: begin
                    src_ready = 1'b1;
                    if (src_valid) st_d = ST_SEND;
                end
                ST_CAPT: begin
                    cap_sample = 1'b1;
                    if (cap_last) st_d = ST_HOLD;
                end
                ST_HOLD: begin
                    st_d = ST_HOLD;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            byte_done <= 1'b0;
            underrun  <= 1'b0;
        end else begin
            st_q      <= st_d;
            byte_done <= done_d;
            underrun  <= unr_d;
        end
    end

    assign tx_load  = src_ready && src_valid;
    assign tx_step  = live && (st_q == ST_SEND) && !tx_last;
    assign lane_oe  = (live && (st_q == ST_SEND)) ? tx_mask : 4'b0000;
    assign lane_out = tx_lanes & lane_oe;

    mlspi_tx_lanes u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (!live),
        .load      (tx_load),
        .load_data (src_data),
        .load_mode (decode_mode(lane_sel)),
        .step      (tx_step),
        .lanes     (tx_lanes),
        .mask      (tx_mask),
        .last_o    (tx_last)
    );

    mlspi_rx_capture #(
        .ADDR_W (ADDR_W),
        .MODE_W (MODE_W)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!live),
        .sample  (cap_sample),
        .din     (cap_lanes),
        .last_o  (cap_last),
        .addr_o  (cap_addr),
        .mode_o  (cap_mode),
        .valid_o (cap_valid)
    );

    // R1: lane enables only take a legal lane-mode shape
    always_comb begin
        if (rst_n) begin
            assert_oe_shape_R1: assert (lane_oe == 4'b0000 || lane_oe == 4'b0001 ||
                                        lane_oe == 4'b0011 || lane_oe == 4'b1111);
        end
    end

    // R4: byte completion is a single-clock strobe
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);

    // R4: an accepted byte is on the lanes in the next cycle
    assert_load_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ready && src_valid) |=> (cs_n || lane_oe != 4'b0000));

    // R5: an underrun always comes with released lanes
    assert_underrun_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (lane_oe == 4'b0000));

    // R6: no transmit strobes follow a deselected clock
    assert_no_strobe_after_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!byte_done && !underrun));

    // R7: lanes stay released while a capture completes
    assert_capture_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> (lane_oe == 4'b0000));

endmodule

// File: tb/mlspi_shifter_tb.sv
module mlspi_shifter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic [1:0]  lane_sel = 2'b00;
    logic        cap_en = 1'b0;
    logic [7:0]  src_data = 8'h00;
    logic        src_valid = 1'b0;
    logic        src_ready;
    logic [3:0]  lane_out, lane_oe;
    logic [1:0]  cap_lanes = 2'b00;
    logic        byte_done, underrun, cap_valid;
    logic [23:0] cap_addr;
    logic [7:0]  cap_mode;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mlspi_shifter dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .lane_sel(lane_sel), .cap_en(cap_en),
        .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
        .lane_out(lane_out), .lane_oe(lane_oe), .cap_lanes(cap_lanes),
        .byte_done(byte_done), .underrun(underrun), .cap_addr(cap_addr),
        .cap_mode(cap_mode), .cap_valid(cap_valid)
    );

    // {lane_sel, byte}
    localparam logic [9:0] VEC [6] = '{10'h0A5, 10'h1A5, 10'h2A5, 10'h13C, 10'h296, 10'h3C3};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int beats(input logic [1:0] m);
        return m[1] ? 2 : (m[0] ? 4 : 8);
    endfunction

    function automatic logic [3:0] exp_oe(input logic [1:0] m);
        return m[1] ? 4'b1111 : (m[0] ? 4'b0011 : 4'b0001);
    endfunction

    function automatic logic [3:0] exp_lanes(input logic [1:0] m, input logic [7:0] d, input int b);
        if (m[1])
            return (b == 0) ? d[7:4] : d[3:0];
        else if (m[0])
            return {2'b00, d[7-2*b], d[6-2*b]};
        else
            return {3'b000, d[7-b]};
    endfunction

    function automatic string mtag(input logic [1:0] m);
        return m[1] ? "R3 quad lanes" : (m[0] ? "R2 dual lanes" : "R1 single lane");
    endfunction

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    // one byte in a select; starts and ends at a falling edge
    task automatic frame_one(input logic [1:0] m, input logic [7:0] d);
        cs_n = 1'b0; lane_sel = m; src_data = d; src_valid = 1'b1;
        tick();
        src_valid = 1'b0;
        for (int b = 0; b < beats(m); b++) begin
            if (b > 0) tick();
            check(mtag(m), {28'd0, lane_out}, {28'd0, exp_lanes(m, d, b)});
            check(mtag(m), {28'd0, lane_oe}, {28'd0, exp_oe(m)});
        end
        check("R4 ready in last beat", {31'd0, src_ready}, 32'd1);
        tick();
        check("R4 byte_done pulse", {31'd0, byte_done}, 32'd1);
        check("R5 underrun pulse", {31'd0, underrun}, 32'd1);
        check("R5 lanes released", {28'd0, lane_oe}, 32'd0);
        cs_n = 1'b1;
        tick();
    endtask

    task automatic capture(input logic [31:0] w);
        cs_n = 1'b0; cap_en = 1'b1;
        for (int k = 0; k < 16; k++) begin
            cap_lanes = {w[31-2*k], w[30-2*k]};
            tick();
            if (k == 7) check("R7 no drive in capture", {28'd0, lane_oe}, 32'd0);
            if (k == 14) check("R7 no early valid", {31'd0, cap_valid}, 32'd0);
        end
        check("R7 capture valid", {31'd0, cap_valid}, 32'd1);
        check("R7 capture address", {8'd0, cap_addr}, {8'd0, w[31:8]});
        check("R7 capture mode", {24'd0, cap_mode}, {24'd0, w[7:0]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R9 reset state
        check("R9 reset oe", {28'd0, lane_oe}, 32'd0);
        check("R9 reset ready", {31'd0, src_ready}, 32'd0);
        check("R9 reset strobes", {29'd0, byte_done, underrun, cap_valid}, 32'd0);

        // R1 R2 R3 table of modes and bytes
        for (int i = 0; i < 6; i++) frame_one(VEC[i][9:8], VEC[i][7:0]);

        // R4 back-to-back dual bytes
        cs_n = 1'b0; lane_sel = 2'b01; src_data = 8'h12; src_valid = 1'b1;
        tick();
        src_valid = 1'b0;
        tick(); tick(); tick();
        check("R4 ready at last beat", {31'd0, src_ready}, 32'd1);
        src_data = 8'h34; src_valid = 1'b1;
        tick();
        src_valid = 1'b0;
        check("R4 chained done", {31'd0, byte_done}, 32'd1);
        check("R4 no underrun when chained", {31'd0, underrun}, 32'd0);
        for (int b = 0; b < 4; b++) begin
            if (b > 0) tick();
            check("R4 chained byte lanes", {28'd0, lane_out}, {28'd0, exp_lanes(2'b01, 8'h34, b)});
        end
        cs_n = 1'b1;
        tick();

        // R5 underrun and resume in quad
        cs_n = 1'b0; lane_sel = 2'b10; src_data = 8'hA1; src_valid = 1'b1;
        tick();
        src_valid = 1'b0;
        tick(); tick();
        check("R5 underrun flagged", {31'd0, underrun}, 32'd1);
        tick();
        check("R5 underrun one clock", {31'd0, underrun}, 32'd0);
        check("R5 stall keeps lanes off", {28'd0, lane_oe}, 32'd0);
        src_data = 8'h5E; src_valid = 1'b1;
        tick();
        src_valid = 1'b0;
        check("R5 resume first beat", {28'd0, lane_out}, 32'h5);
        check("R5 resume enables", {28'd0, lane_oe}, 32'hF);
        cs_n = 1'b1;
        tick();

        // R6 deselect mid-byte
        cs_n = 1'b0; lane_sel = 2'b00; src_data = 8'hF0; src_valid = 1'b1;
        tick();
        src_valid = 1'b0;
        tick(); tick();
        cs_n = 1'b1;
        #1;
        check("R6 oe off at deselect", {28'd0, lane_oe}, 32'd0);
        check("R6 ready off at deselect", {31'd0, src_ready}, 32'd0);
        @(negedge clk);
        check("R6 no done after abort", {31'd0, byte_done}, 32'd0);
        cs_n = 1'b0; src_data = 8'h7F; src_valid = 1'b1;
        tick();
        src_valid = 1'b0;
        check("R6 fresh byte beat0", {28'd0, lane_out}, 32'd0);
        tick();
        check("R6 fresh byte beat1", {28'd0, lane_out}, 32'd1);
        cs_n = 1'b1;
        tick();

        // R10 mode change mid-byte
        cs_n = 1'b0; lane_sel = 2'b00; src_data = 8'hAA; src_valid = 1'b1;
        tick();
        src_valid = 1'b0;
        check("R10 beat0", {28'd0, lane_out}, 32'd1);
        lane_sel = 2'b10;
        tick();
        check("R10 mode held oe", {28'd0, lane_oe}, 32'd1);
        check("R10 mode held data", {28'd0, lane_out}, 32'd0);
        cs_n = 1'b1; lane_sel = 2'b00;
        tick();

        // R7 capture, R8 ignore after done
        capture({24'hABCDEF, 8'h5A});
        seen = 1'b0;
        for (int k = 0; k < 16; k++) begin
            cap_lanes = k[1:0];
            tick();
            if (cap_valid) seen = 1'b1;
        end
        check("R8 no second valid", {31'd0, seen}, 32'd0);
        check("R8 address kept", {8'd0, cap_addr}, 32'hABCDEF);
        cs_n = 1'b1; cap_en = 1'b0;
        tick();

        // R8 abort mid-capture then full capture
        cs_n = 1'b0; cap_en = 1'b1;
        for (int k = 0; k < 5; k++) begin
            cap_lanes = 2'b11;
            tick();
        end
        cs_n = 1'b1;
        tick();
        capture({24'h123456, 8'hC3});
        cs_n = 1'b1; cap_en = 1'b0;
        tick();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule